// File: doc/BRIEF.md
# Receive Overrun and Timeout Interrupt Logic

This block sits next to the receive FIFO of a serial port and turns two receive-side conditions into interrupt flags. An overrun is raised when a complete frame arrives while the FIFO is already full. The incoming frame is discarded and the FIFO keeps its contents. A timeout is raised when the FIFO has held data for a fixed number of serial bit periods without being read. The default is 32 bit periods.

Bit periods come from a one-cycle strobe, `bit_tick_i`, produced by the port's rate divider. That divider runs at the system clock divided by the prescale value times (serial clock rate + 1). The timeout therefore scales with the programmed bit rate and is the same in master and slave operation.

Software sees three readable registers: raw flags, a mask, and the masked flags. A fourth register is write-one-to-clear. All four sit on a simple single-cycle register port. The interrupt output is the OR of the masked flags.

Top module: `rx_irq_ctrl`

## Requirements
- R1: A cycle with `frame_done_i` and `fifo_full_i` both high sets the overrun flag (bit 0) on the next clock edge. A frame that arrives while the FIFO is not full does not set it.
- R2: `drop_frame_o` is high in exactly the cycles where `frame_done_i` and `fifo_full_i` are both high, which tells the FIFO to discard the frame.
- R3: With `fifo_not_empty_i` high and no restart, the timeout flag (bit 1) is set at the edge of the 32nd `bit_tick_i` pulse. After 31 pulses it is still clear. System clock cycles between pulses do not count.
- R4: The timeout count returns to zero on `fifo_rd_i`, or on an accepted frame (`frame_done_i` with `fifo_full_i` low). It stays at zero while `fifo_not_empty_i` is low.
- R5: Once the count has fired, it holds without firing again until it is restarted. A timeout flag that is cleared after firing stays clear under further ticks.
- R6: Writing address 3 clears the overrun flag where `reg_wdata_i[0]` is 1 and the timeout flag where `reg_wdata_i[1]` is 1. Zero bits and bits 31:2 have no effect.
- R7: If a set event and a clear of the same flag fall in the same cycle, the flag is set afterwards.
- R8: The mask register at address 0 holds bits 1:0 (bit 0 overrun, bit 1 timeout). It resets to 0 and reads 0 in bits 31:2.
- R9: Address 1 reads the raw flags and address 2 reads raw AND mask, both in bits 1:0. Address 3 reads 0.
- R10: `irq_o` is high exactly when some raw flag and its mask bit are both 1.
- R11: After reset both flags are 0, the mask is 0 and `irq_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_done_i | input | 1 | A received frame is complete this cycle |
| fifo_full_i | input | 1 | Receive FIFO is full |
| fifo_not_empty_i | input | 1 | Receive FIFO holds at least one word |
| fifo_rd_i | input | 1 | Receive FIFO is read this cycle |
| bit_tick_i | input | 1 | One-cycle strobe per serial bit period |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational from address |
| drop_frame_o | output | 1 | Discard the incoming frame (overrun) |
| irq_o | output | 1 | Combined masked interrupt |

## Verification
The hardest situation to reach is a timeout that fires in the same cycle as a write that clears it. The count must sit exactly one tick short of the limit when the clear lands. The bench gets there by restarting the count through a low `fifo_not_empty_i` and issuing exactly 31 ticks. It then drives the 32nd tick and the clear write in one cycle. Restart timing is swept across every tick position 0 to 31, using both FIFO reads and accepted frames.

// File: rtl/rx_irq_pkg.sv
package rx_irq_pkg;
  localparam int IRQ_N   = 2;
  localparam int IDX_OVR = 0;
  localparam int IDX_TMO = 1;
  localparam int ADDR_W  = 2;
  localparam logic [ADDR_W-1:0] A_MASK = 2'd0;
  localparam logic [ADDR_W-1:0] A_RAW  = 2'd1;
  localparam logic [ADDR_W-1:0] A_MIS  = 2'd2;
  localparam logic [ADDR_W-1:0] A_CLR  = 2'd3;
endpackage

// File: rtl/rx_tmo_counter.sv
module rx_tmo_counter #(
  parameter int TIMEOUT_BITS = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic not_empty_i,
  input  logic restart_i,
  input  logic tick_i,
  output logic fire_o
);
  localparam int CNT_W = $clog2(TIMEOUT_BITS + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(TIMEOUT_BITS);
  localparam logic [CNT_W-1:0] LAST  = CNT_W'(TIMEOUT_BITS - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             hold;

  assign hold   = !not_empty_i || restart_i;
  assign fire_o = !hold && tick_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (hold)                    cnt_q <= '0;
    else if (tick_i && cnt_q != LIMIT) cnt_q <= cnt_q + CNT_W'(1);
  end

  // R5
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LIMIT);
  // R4
  empty_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!not_empty_i || restart_i) |=> cnt_q == '0);
  // R5
  fire_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_o |=> cnt_q == LIMIT);
endmodule

// File: rtl/rx_irq_flag.sv
module rx_irq_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_o <= 1'b0;
    else if (set_i)  flag_o <= 1'b1;
    else if (clr_i)  flag_o <= 1'b0;
  end

  // R7
  set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> flag_o);
  // R6
  clr_takes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> !flag_o);
  // R6
  sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!set_i && !clr_i) |=> $stable(flag_o));
endmodule

// File: rtl/rx_irq_regs.sv
module rx_irq_regs
  import rx_irq_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [IRQ_N-1:0]  raw_i,
  output logic [IRQ_N-1:0]  mask_o,
  output logic [IRQ_N-1:0]  clr_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic unused_hi;
  assign unused_hi = ^wdata_i[DATA_W-1:IRQ_N];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      mask_o <= '0;
    else if (wr_i && addr_i == A_MASK) mask_o <= wdata_i[IRQ_N-1:0];
  end

  assign clr_o = (wr_i && addr_i == A_CLR) ? wdata_i[IRQ_N-1:0] : '0;

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_MASK:  rdata_o[IRQ_N-1:0] = mask_o;
      A_RAW:   rdata_o[IRQ_N-1:0] = raw_i;
      A_MIS:   rdata_o[IRQ_N-1:0] = raw_i & mask_o;
      default: rdata_o = '0;
    endcase
  end

  // R8
  mask_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && addr_i == A_MASK) |=> $stable(mask_o));
endmodule

// File: rtl/rx_irq_ctrl.sv
module rx_irq_ctrl
  import rx_irq_pkg::*;
#(
  parameter int DATA_W       = 32,
  parameter int TIMEOUT_BITS = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_done_i,
  input  logic              fifo_full_i,
  input  logic              fifo_not_empty_i,
  input  logic              fifo_rd_i,
  input  logic              bit_tick_i,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              drop_frame_o,
  output logic              irq_o
);
  logic [IRQ_N-1:0] set_vec, clr_vec, raw, mask;
  logic             push_ok, restart, tmo_fire;

  assign drop_frame_o = frame_done_i && fifo_full_i;
  assign push_ok      = frame_done_i && !fifo_full_i;
  assign restart      = fifo_rd_i || push_ok;

  rx_tmo_counter #(.TIMEOUT_BITS(TIMEOUT_BITS)) u_tmo (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .not_empty_i (fifo_not_empty_i),
    .restart_i   (restart),
    .tick_i      (bit_tick_i),
    .fire_o      (tmo_fire)
  );

  assign set_vec[IDX_OVR] = drop_frame_o;
  assign set_vec[IDX_TMO] = tmo_fire;

  for (genvar i = 0; i < IRQ_N; i++) begin : g_flag
    rx_irq_flag u_flag (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (set_vec[i]),
      .clr_i  (clr_vec[i]),
      .flag_o (raw[i])
    );
  end

  rx_irq_regs #(.DATA_W(DATA_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (reg_wr_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .raw_i   (raw),
    .mask_o  (mask),
    .clr_o   (clr_vec),
    .rdata_o (reg_rdata_o)
  );

  assign irq_o = |(raw & mask);

  // R1
  ovr_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_done_i && fifo_full_i) |=> raw[IDX_OVR]);
  // R10
  irq_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (mask != '0) && (raw != '0));
endmodule

// File: tb/rx_irq_ctrl_tb.sv
module rx_irq_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_done = 0, fifo_full = 0, not_empty = 0, fifo_rd = 0, tick = 0;
  logic        wr = 0;
  logic [1:0]  addr = 0;
  logic [31:0] wdata = 0;
  logic [31:0] rdata;
  logic        drop, irq;
  int          n_chk = 0, n_err = 0;

  always #2 clk = ~clk;

  rx_irq_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .frame_done_i(frame_done), .fifo_full_i(fifo_full),
    .fifo_not_empty_i(not_empty), .fifo_rd_i(fifo_rd), .bit_tick_i(tick),
    .reg_wr_i(wr), .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .drop_frame_o(drop), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic wreg(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); wr = 1; addr = a; wdata = d;
    @(negedge clk); wr = 0; wdata = 0;
  endtask

  task automatic ticks(input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1;
      @(negedge clk); tick = 0;
      repeat (gap) @(negedge clk);
    end
  endtask

  task automatic restart_empty();
    @(negedge clk); not_empty = 0;
    @(negedge clk); not_empty = 1;
  endtask

  task automatic overrun();
    @(negedge clk); frame_done = 1; fifo_full = 1;
    #1 chk("R2 drop on full", {31'd0, drop}, 32'd1);
    @(negedge clk); frame_done = 0; fifo_full = 0;
  endtask

  task automatic set_raw(input logic [1:0] r);
    wreg(2'd3, 32'd3);
    restart_empty();
    if (r[0]) overrun();
    if (r[1]) ticks(32, 0);
    @(negedge clk); not_empty = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R11 reset state, R8/R9 read-back
    for (int a = 0; a < 4; a++) begin
      rd(a[1:0], d); chk("R11 reset reg", d, 32'd0);
    end
    chk("R11 irq reset", {31'd0, irq}, 32'd0);

    // R3 tick sweep with varying clock gaps
    for (int k = 1; k <= 36; k++) begin
      wreg(2'd3, 32'd2);
      restart_empty();
      ticks(k, k % 3);
      rd(2'd1, d);
      chk("R3 timeout after k ticks", {31'd0, d[1]}, {31'd0, k >= 32});
    end
    // R5 no refire after clear without restart
    wreg(2'd3, 32'd2);
    ticks(10, 0);
    rd(2'd1, d); chk("R5 no refire", {31'd0, d[1]}, 32'd0);

    // R4 restart by read or accepted frame at every position
    for (int r = 0; r < 32; r++) begin
      wreg(2'd3, 32'd3);
      restart_empty();
      ticks(r, 0);
      @(negedge clk);
      if (r % 2 == 0) fifo_rd = 1; else frame_done = 1;
      @(negedge clk); fifo_rd = 0; frame_done = 0;
      ticks(31, 0);
      rd(2'd1, d); chk("R4 restart at 31", d, 32'd0);
      ticks(1, 0);
      rd(2'd1, d); chk("R4 restart at 32", d, 32'd2);
    end
    // R4 ticks while empty do not count
    wreg(2'd3, 32'd3);
    @(negedge clk); not_empty = 0;
    ticks(50, 0);
    @(negedge clk); not_empty = 1;
    ticks(31, 0);
    rd(2'd1, d); chk("R4 empty hold", d, 32'd0);
    @(negedge clk); not_empty = 0;

    // R1/R2 overrun vs accepted frame
    wreg(2'd3, 32'd3);
    @(negedge clk); frame_done = 1; fifo_full = 0;
    #1 chk("R2 no drop when not full", {31'd0, drop}, 32'd0);
    @(negedge clk); frame_done = 0;
    rd(2'd1, d); chk("R1 no overrun when not full", d, 32'd0);
    @(negedge clk); fifo_full = 1;
    #1 chk("R2 full without frame", {31'd0, drop}, 32'd0);
    @(negedge clk); fifo_full = 0;
    overrun();
    rd(2'd1, d); chk("R1 overrun set", d, 32'd1);

    // R6 clear patterns
    for (int p = 0; p < 8; p++) begin
      logic [31:0] pat;
      pat = {p[2] ? 30'h3FFF_FFFF : 30'h0, p[1:0]};
      set_raw(2'b11);
      rd(2'd1, d); chk("R6 both set", d, 32'd3);
      wreg(2'd3, pat);
      rd(2'd1, d); chk("R6 clear pattern", d, {30'd0, ~pat[1:0]});
    end

    // R7 set and clear in same cycle
    wreg(2'd3, 32'd3);
    @(negedge clk); frame_done = 1; fifo_full = 1; wr = 1; addr = 2'd3; wdata = 32'd1;
    @(negedge clk); frame_done = 0; fifo_full = 0; wr = 0; wdata = 0;
    rd(2'd1, d); chk("R7 overrun set beats clear", d, 32'd1);
    wreg(2'd3, 32'd3);
    restart_empty();
    ticks(31, 0);
    @(negedge clk); tick = 1; wr = 1; addr = 2'd3; wdata = 32'd2;
    @(negedge clk); tick = 0; wr = 0; wdata = 0;
    rd(2'd1, d); chk("R7 timeout set beats clear", d, 32'd2);
    @(negedge clk); not_empty = 0;

    // R8/R9/R10 mask x raw sweep
    for (int r = 0; r < 4; r++) begin
      for (int m = 0; m < 4; m++) begin
        logic [1:0] e;
        set_raw(r[1:0]);
        wreg(2'd0, 32'hFFFF_FFF0 | m);
        e = r[1:0] & m[1:0];
        rd(2'd0, d); chk("R8 mask readback", d, m);
        rd(2'd1, d); chk("R9 raw", d, r);
        rd(2'd2, d); chk("R9 masked", d, {30'd0, e});
        rd(2'd3, d); chk("R9 clear reads zero", d, 32'd0);
        chk("R10 irq", {31'd0, irq}, {31'd0, |e});
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end
endmodule